// File: doc/BRIEF.md
# Phase-Shifted Carrier Modulator for a Cascaded Full-Bridge Phase

This block generates the switch commands for one phase of a cascaded inverter built from `NCELL` series full-bridge cells. Each cell can place +Vdc, 0 or -Vdc on its output terminals. The series string therefore reaches `2*NCELL+1` distinct phase levels. A single signed reference sample is shared by all cells. Each cell compares that reference against its own triangular carrier, and the carriers are spread evenly across one carrier period. Dead time, DC-source balancing and reference synthesis are handled elsewhere.

One shared counter and a two-state sequencer produce the carrier time base. In state `SEQ_HOLD`, every bridge is parked in its zero state. The *start* transition moves to `SEQ_RUN` as soon as the half-period input is non-zero. In `SEQ_RUN`, the counter steps through one carrier period. At the last count, the *wrap* transition reloads the half-period. If the reloaded value is zero, the *stop* transition returns the sequencer to `SEQ_HOLD`. Each cell turns the shared count into its own carrier by adding a fixed phase offset. It then selects a unipolar code (+1, 0 or -1) and registers four gate bits from that code. A separate adder registers the signed sum of the cell codes.

Top module: `pscm_modulator`

## Requirements
- R1: Across a full-scale sinusoidal reference sweep, the phase level output takes every value from -NCELL to +NCELL, which is 2*NCELL+1 levels.
- R2: Cell k drives gate bits 4k+0 (left upper), 4k+1 (left lower), 4k+2 (right upper) and 4k+3 (right lower). Left upper is on exactly when the reference is greater than the cell's carrier. Right upper is on exactly when the negated reference is greater than the carrier. Cell code = left upper minus right upper, so code +1 is 4'b1001, -1 is 4'b0110 and 0 is 4'b1010.
- R3: With half-period H, the shared count runs 0..2H-1 and then returns to 0. A cell whose phase is p has carrier p when p < H and 2H-1-p otherwise.
- R4: The phase of cell k is (count + floor(k*2H/NCELL)) mod 2H.
- R5: The level output equals the sum of the cell codes. Gates and level are both registered one clock after the count and reference they are computed from.
- R6: In every leg, the upper and lower gate bits are always complementary.
- R7: The level output always lies within -NCELL..+NCELL.
- R8: While reset is low, every cell shows 4'b1010 and the level is 0.
- R9: In `SEQ_HOLD`, all cells show 4'b1010 on the next clock. A zero half-period holds or returns the sequencer to `SEQ_HOLD` (returning only at a wrap). A non-zero half-period in `SEQ_HOLD` starts `SEQ_RUN` with count 0.
- R10: A change of the half-period during `SEQ_RUN` takes effect only at the wrap edge. The period in progress completes with the old value.
- R11: A reference of at least H forces every cell to +1. A reference of at most -H (down to the most negative code) forces every cell to -1. A reference of 0 forces every cell to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_in | input | PW+1 | Signed reference sample, in carrier units |
| period_in | input | PW | Carrier half-period H in clocks; 0 stops modulation |
| gates | output | 4*NCELL | Four gate bits per cell, cell k at bits 4k+3..4k |
| level | output | LW | Signed sum of cell codes, LW = clog2(NCELL+1)+1 |

## Verification
Each gate word and level value is due one clock edge after the count and reference it depends on. A half-period presented in `SEQ_HOLD` produces its first non-zero gate word two edges later. A half-period change in `SEQ_RUN` first alters the carriers on the edge after the next wrap. The bench keeps its own count, half-period and run flag, advanced at the same edges the design uses, and pushes one predicted gate word and level per edge into a queue. A monitor pops each prediction on the following falling edge, so every comparison lands exactly one edge after the inputs it was computed from.

// File: rtl/pscm_pkg.sv
package pscm_pkg;

    // Sequencer states for the shared carrier time base
    typedef enum logic [0:0] {
        SEQ_HOLD = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Per-cell bridge code
    typedef enum logic [1:0] {
        CODE_ZERO = 2'b00,
        CODE_POS  = 2'b01,
        CODE_NEG  = 2'b11
    } cell_code_e;

    // Gate words: bit0 left upper, bit1 left lower, bit2 right upper, bit3 right lower
    localparam logic [3:0] GATE_ZERO = 4'b1010;
    localparam logic [3:0] GATE_POS  = 4'b1001;
    localparam logic [3:0] GATE_NEG  = 4'b0110;

endpackage

// File: rtl/pscm_seq.sv
module pscm_seq
    import pscm_pkg::*;
#(
    parameter int PW = 8,
    localparam int CW = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] period_in,
    output seq_state_e    st_q,
    output logic [CW-1:0] cnt_q,
    output logic [PW-1:0] hlat_q,
    output logic          run
);

    seq_state_e    st_d;
    logic [CW-1:0] cnt_d;
    logic [PW-1:0] hlat_d;
    logic [CW-1:0] last_cnt;
    logic          at_wrap;

    // Final count of the current period: 2H-1
    assign last_cnt = {hlat_q, 1'b0} - CW'(1);
    assign at_wrap  = (cnt_q == last_cnt);

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= SEQ_HOLD;
            cnt_q  <= '0;
            hlat_q <= '0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            hlat_q <= hlat_d;
        end
    end

    // Next-state process
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        hlat_d = hlat_q;
        unique case (st_q)
            SEQ_HOLD: begin
                // start: any non-zero half-period launches a fresh carrier
                if (period_in != '0) begin
                    st_d   = SEQ_RUN;
                    cnt_d  = '0;
                    hlat_d = period_in;
                end
            end
            SEQ_RUN: begin
                if (at_wrap) begin
                    // wrap: reload; stop when the new half-period is zero
                    cnt_d  = '0;
                    hlat_d = period_in;
                    if (period_in == '0) begin
                        st_d = SEQ_HOLD;
                    end
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            default: begin
                st_d = SEQ_HOLD;
            end
        endcase
    end

    // Output process
    always_comb begin
        run = (st_q == SEQ_RUN);
    end

endmodule

// File: rtl/pscm_cell.sv
module pscm_cell
    import pscm_pkg::*;
#(
    parameter int PW    = 8,
    parameter int NCELL = 4,
    parameter int IDX   = 0,
    localparam int CW   = PW + 1,
    localparam int XW   = PW + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic [CW-1:0]        cnt,
    input  logic [PW-1:0]        hlat,
    input  logic signed [PW:0]   ref_in,
    output cell_code_e           code_d,
    output logic [3:0]           gates
);

    logic [CW-1:0]        span;
    logic [CW-1:0]        offset;
    logic [CW:0]          ph_sum;
    logic [CW-1:0]        phase;
    logic [CW-1:0]        carrier;
    logic signed [XW-1:0] ref_x;
    logic signed [XW-1:0] neg_x;
    logic signed [XW-1:0] carr_x;
    logic                 left_on;
    logic                 right_on;

    assign span = {hlat, 1'b0};

    // Phase-shifted triangular carrier derived from the shared count
    always_comb begin
        offset = CW'((32'(span) * 32'(IDX)) / 32'(NCELL));
        ph_sum = {1'b0, cnt} + {1'b0, offset};
        if (ph_sum >= {1'b0, span}) begin
            phase = CW'(ph_sum - {1'b0, span});
        end else begin
            phase = CW'(ph_sum);
        end
        if (phase < {1'b0, hlat}) begin
            carrier = phase;
        end else begin
            carrier = span - phase - CW'(1);
        end
    end

    // Unipolar comparison, widened so that negation cannot overflow
    always_comb begin
        ref_x    = {ref_in[PW], ref_in};
        neg_x    = -ref_x;
        carr_x   = {1'b0, carrier};
        left_on  = (ref_x > carr_x);
        right_on = (neg_x > carr_x);
        case ({left_on, right_on})
            2'b10:   code_d = CODE_POS;
            2'b01:   code_d = CODE_NEG;
            default: code_d = CODE_ZERO;
        endcase
    end

    // Registered gate word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gates <= GATE_ZERO;
        end else if (!run) begin
            gates <= GATE_ZERO;
        end else begin
            case (code_d)
                CODE_POS: gates <= GATE_POS;
                CODE_NEG: gates <= GATE_NEG;
                default:  gates <= GATE_ZERO;
            endcase
        end
    end

endmodule

// File: rtl/pscm_level_sum.sv
module pscm_level_sum
    import pscm_pkg::*;
#(
    parameter int NCELL = 4,
    parameter int LW    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic [2*NCELL-1:0]    codes,
    output logic signed [LW-1:0]  level
);

    logic signed [LW-1:0] acc;

    always_comb begin
        acc = '0;
        for (int k = 0; k < NCELL; k++) begin
            case (cell_code_e'(codes[2*k +: 2]))
                CODE_POS: acc = acc + LW'(1);
                CODE_NEG: acc = acc - LW'(1);
                default:  acc = acc;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level <= '0;
        end else if (!run) begin
            level <= '0;
        end else begin
            level <= acc;
        end
    end

endmodule

// File: rtl/pscm_modulator.sv
module pscm_modulator
    import pscm_pkg::*;
#(
    parameter int NCELL = 4,
    parameter int PW    = 8,
    localparam int CW   = PW + 1,
    localparam int LW   = $clog2(NCELL + 1) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic signed [PW:0]    ref_in,
    input  logic [PW-1:0]         period_in,
    output logic [4*NCELL-1:0]    gates,
    output logic signed [LW-1:0]  level
);

    seq_state_e         seq_st;
    logic [CW-1:0]      seq_cnt;
    logic [PW-1:0]      seq_hlat;
    logic               seq_run;
    cell_code_e         cell_code [NCELL];
    logic [2*NCELL-1:0] code_bus;

    pscm_seq #(.PW(PW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .period_in (period_in),
        .st_q      (seq_st),
        .cnt_q     (seq_cnt),
        .hlat_q    (seq_hlat),
        .run       (seq_run)
    );

    for (genvar g = 0; g < NCELL; g++) begin : g_cell
        pscm_cell #(.PW(PW), .NCELL(NCELL), .IDX(g)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (seq_run),
            .cnt    (seq_cnt),
            .hlat   (seq_hlat),
            .ref_in (ref_in),
            .code_d (cell_code[g]),
            .gates  (gates[4*g +: 4])
        );
        assign code_bus[2*g +: 2] = cell_code[g];
    end

    pscm_level_sum #(.NCELL(NCELL), .LW(LW)) u_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (seq_run),
        .codes (code_bus),
        .level (level)
    );

endmodule

// File: rtl/pscm_modulator_chk.sv
module pscm_modulator_chk
    import pscm_pkg::*;
#(
    parameter int NCELL = 4,
    parameter int PW    = 8,
    localparam int CW   = PW + 1,
    localparam int LW   = $clog2(NCELL + 1) + 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [4*NCELL-1:0]   gates,
    input logic signed [LW-1:0] level,
    input seq_state_e           st_q,
    input logic [CW-1:0]        cnt_q,
    input logic [PW-1:0]        hlat_q
);

    int gate_sum;

    always_comb begin
        gate_sum = 0;
        for (int k = 0; k < NCELL; k++) begin
            gate_sum = gate_sum + int'(gates[4*k]) - int'(gates[4*k+2]);
        end
    end

    // R7: level never leaves -NCELL..+NCELL
    assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(level) <= NCELL) && (int'(level) >= -NCELL));

    // R5: adder result agrees with the code implied by the gate registers
    assert_level_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(level) == gate_sum);

    // R6: each leg complementary
    for (genvar j = 0; j < 2*NCELL; j++) begin : g_leg
        assert_leg_compl_R6: assert property (@(posedge clk) disable iff (!rst_n)
            gates[2*j] != gates[2*j+1]);
    end

    // R9: hold state parks every bridge at zero on the next edge
    assert_hold_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SEQ_HOLD) |=> (gates == {NCELL{GATE_ZERO}}) && (level == '0));

    // R3: count stays inside the carrier period
    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SEQ_RUN) |-> (cnt_q < {hlat_q, 1'b0}));

    // R10: half-period only changes at a wrap
    assert_period_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == SEQ_RUN) && (cnt_q != ({hlat_q, 1'b0} - CW'(1)))) |=> $stable(hlat_q));

endmodule

bind pscm_modulator pscm_modulator_chk #(.NCELL(NCELL), .PW(PW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .gates  (gates),
    .level  (level),
    .st_q   (seq_st),
    .cnt_q  (seq_cnt),
    .hlat_q (seq_hlat)
);

// File: tb/pscm_modulator_test.sv
module pscm_modulator_test;

    localparam int NCELL = 4;
    localparam int PW    = 8;
    localparam int LW    = $clog2(NCELL + 1) + 1;
    localparam int GW    = 4 * NCELL;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic signed [PW:0]   ref_in;
    logic [PW-1:0]        period_in;
    logic [GW-1:0]        gates;
    logic signed [LW-1:0] level;

    int    checks = 0;
    int    bad = 0;
    int    cyc = 0;
    string tag = "R8";
    bit    seen [2*NCELL+1];

    logic [GW-1:0] q_g [$];
    int            q_l [$];

    int m_run = 0;
    int m_cnt = 0;
    int m_h   = 0;

    pscm_modulator #(.NCELL(NCELL), .PW(PW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_in    (ref_in),
        .period_in (period_in),
        .gates     (gates),
        .level     (level)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Independent model of the requirements
    function automatic void predict(input int cnt, input int h, input int r,
                                    output logic [GW-1:0] g, output int lv);
        lv = 0;
        g  = '0;
        for (int k = 0; k < NCELL; k++) begin
            int off;
            int p;
            int c;
            bit l;
            bit rr;
            off = (k * 2 * h) / NCELL;
            p   = cnt + off;
            if (p >= 2 * h) p = p - 2 * h;
            c   = (p < h) ? p : (2 * h - 1 - p);
            l   = (r > c);
            rr  = (-r > c);
            g[4*k+0] = l;
            g[4*k+1] = !l;
            g[4*k+2] = rr;
            g[4*k+3] = !rr;
            lv = lv + int'(l) - int'(rr);
        end
    endfunction

    // Driver side of the scoreboard: one prediction per edge
    always @(posedge clk) begin
        logic [GW-1:0] g;
        int lv;
        if (!rst_n) begin
            g = {NCELL{4'b1010}};
            lv = 0;
            m_run = 0;
            m_cnt = 0;
            m_h = 0;
        end else begin
            if (m_run != 0) begin
                predict(m_cnt, m_h, int'(ref_in), g, lv);
            end else begin
                g = {NCELL{4'b1010}};
                lv = 0;
            end
            if (m_run == 0) begin
                if (period_in != '0) begin
                    m_run = 1;
                    m_cnt = 0;
                    m_h = int'(period_in);
                end
            end else if (m_cnt == 2 * m_h - 1) begin
                m_cnt = 0;
                m_h = int'(period_in);
                if (period_in == '0) m_run = 0;
            end else begin
                m_cnt++;
            end
        end
        q_g.push_back(g);
        q_l.push_back(lv);
    end

    // Monitor side of the scoreboard
    always @(negedge clk) begin
        if (q_g.size() > 0) begin
            logic [GW-1:0] eg;
            int el;
            eg = q_g.pop_front();
            el = q_l.pop_front();
            chk(gates === eg, tag, "gates", int'(gates), int'(eg));
            chk(int'(level) == el, tag, "level", int'(level), el);
            for (int j = 0; j < 2 * NCELL; j++) begin
                chk(gates[2*j] != gates[2*j+1], "R6", "leg complement", int'(gates[2*j +: 2]), 1);
            end
            chk((int'(level) <= NCELL) && (int'(level) >= -NCELL), "R7", "level bound",
                int'(level), NCELL);
            if ((int'(level) <= NCELL) && (int'(level) >= -NCELL)) begin
                seen[int'(level) + NCELL] = 1'b1;
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++;
            bad++;
            $display("FAIL watchdog cycles=%0d expected<=%0d", cyc, 100000);
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    task automatic sine_run(input int n, input int amp, input int spc);
        for (int i = 0; i < n; i++) begin
            real v;
            v = real'(amp) * $sin(2.0 * 3.14159265358979 * real'(i) / real'(spc));
            ref_in = (PW+1)'($rtoi(v));
            @(negedge clk);
        end
    endtask

    task automatic hold_ref(input int r, input int n);
        ref_in = (PW+1)'(r);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        ref_in = '0;
        period_in = '0;
        tag = "R8";
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(gates == {NCELL{4'b1010}}, "R8", "reset gates", int'(gates), int'({NCELL{4'b1010}}));
        chk(level == '0, "R8", "reset level", int'(level), 0);
        rst_n = 1'b1;

        // R9: zero half-period keeps hold
        tag = "R9";
        hold_ref(60, 6);
        chk(gates == {NCELL{4'b1010}}, "R9", "hold gates", int'(gates), int'({NCELL{4'b1010}}));

        // R2 R3 R4 R5 with a full-scale sweep, H=10
        tag = "R2 R3 R4 R5";
        period_in = 8'd10;
        for (int i = 0; i < 2 * NCELL + 1; i++) seen[i] = 1'b0;
        sine_run(480, 11, 160);
        for (int i = 0; i < 2 * NCELL + 1; i++) begin
            chk(seen[i], "R1", "level value observed", int'(seen[i]), 1);
        end

        // R11: extreme and zero references
        tag = "R11";
        hold_ref(10, 40);
        chk(int'(level) == NCELL, "R11", "level at +H", int'(level), NCELL);
        hold_ref(-10, 40);
        chk(int'(level) == -NCELL, "R11", "level at -H", int'(level), -NCELL);
        hold_ref(0, 30);
        chk(int'(level) == 0, "R11", "level at zero", int'(level), 0);
        hold_ref(255, 20);
        hold_ref(-256, 20);
        chk(gates == {NCELL{4'b0110}}, "R11", "gates at most negative", int'(gates),
            int'({NCELL{4'b0110}}));

        // R10 R4: change half-period in mid period, odd split of offsets
        tag = "R10 R4";
        repeat (3) @(negedge clk);
        period_in = 8'd7;
        sine_run(300, 8, 90);

        // R9: stop at wrap, then restart
        tag = "R9";
        period_in = 8'd0;
        hold_ref(5, 40);
        chk(gates == {NCELL{4'b1010}}, "R9", "stopped gates", int'(gates), int'({NCELL{4'b1010}}));
        chk(int'(level) == 0, "R9", "stopped level", int'(level), 0);
        tag = "R3 R4 R9";
        period_in = 8'd13;
        sine_run(260, 14, 130);

        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule